// File: doc/BRIEF.md
# Streamed Opcode Boot Bridge

This block sits on the cartridge side of a 6502-style console bus. It lets the CPU execute code that an external device streams in, with no program memory on the cartridge. A decoder watches the CPU address bus. On reads of the reset vector it returns bytes that point the CPU at the first of the two controller-port addresses. On reads of the three bytes just past the second port address it returns an absolute jump back to that same port address. The CPU therefore loops forever over the two port addresses, fetching opcodes and operands from them.

The external device supplies the byte for each port read as a serial stream. The bit arrives inverted on the port data line. Each bit is taken on a falling edge of the interrupt-request line, which the CPU ignores while its interrupt mask is set. Once eight bits have been captured inside one read cycle, the block drives the assembled byte onto the data bus until that cycle ends. The console may already drive some of the data lines itself, so the cartridge drives only the bits that a per-bit mask allows. The model is sampled by a fast system clock. Bus phase, interrupt line and serial data are plain logic inputs, and each line's drive is shown by an output-enable bit.

Top module: `stream_boot_bridge`

## Requirements
- R1: While `rst_n` is low, `data_oe` is all zeros and `data_out` is zero, whatever the bus inputs are.
- R2: During a read (`cpu_rw`=1) with `m2` high, address 0xFFFC returns 0x16 and address 0xFFFD returns 0x40. In both cases `data_oe` equals `drive_mask`.
- R3: During a read with `m2` high, addresses 0x4018, 0x4019 and 0x401A return 0x4C, 0x16 and 0x40 in that order (absolute jump to 0x4016). In each case `data_oe` equals `drive_mask`.
- R4: During a read of 0x4016 or 0x4017 with `m2` high, each clock in which `irq_n` is sampled low after being sampled high captures one bit. The captured bit is the inverse of `port_d1_n`.
- R5: Bits are assembled MSB first: the first captured bit lands in bit 7. `data_oe` stays zero on a port read until the eighth bit is captured. From the clock edge that captures the eighth bit, `data_out` shows the byte and `data_oe` equals `drive_mask`.
- R6: Falling edges of `irq_n` after the eighth, within the same port read, change nothing: the driven byte stays the same.
- R7: The bit count and the captured bits clear when `m2` is low or the address is not a port address. The next port read needs eight fresh edges, and edges seen outside a port read are never counted.
- R8: `data_oe` never has a bit set where `drive_mask` is zero. Masked bits are released while the other bits are driven.
- R9: Writes, cycles with `m2` low, and reads of any other address (for example 0x401B or 0x0000) give `data_oe` all zeros and `data_out` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock, much faster than the bus cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | 1 = CPU read, 0 = CPU write |
| m2 | input | 1 | Bus data phase, high while a transfer is valid |
| irq_n | input | 1 | Interrupt-request line used as the serial bit clock (falling edge) |
| port_d1_n | input | 1 | Serial data from the controller port, inverted |
| drive_mask | input | 8 | Per-bit permission to drive the data bus |
| data_out | output | 8 | Byte presented to the data bus |
| data_oe | output | 8 | Per-bit output enable for the data bus |

## Verification
Several rules are checked by assertions on every cycle: the quiet bus during reset, writes and the low phase of `m2`; the mask bound on `data_oe`; the fixed vector bytes; one counted bit per captured edge; the rule that a port read is driven only after all eight bits; the frozen byte after capture; and the clear when `m2` falls. Other behaviours can only be shown by the bench's scenarios. These are the bit order and polarity of the assembled byte, the jump stub sequence, that extra edges leave the byte alone, and that an aborted capture or edges outside a port read leave nothing behind for the next read. The bench's reference model predicts every output on every clock through these sequences.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

  // Which source feeds the data bus in the current cycle.
  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_VEC_LO = 3'd1,
    SRC_VEC_HI = 3'd2,
    SRC_JMP_OP = 3'd3,
    SRC_JMP_LO = 3'd4,
    SRC_JMP_HI = 3'd5,
    SRC_PORT   = 3'd6
  } src_e;

  // The stub is opcode plus two address bytes.
  localparam int unsigned STUB_LEN   = 3;
  // The reset vector is two bytes.
  localparam int unsigned VEC_LEN    = 2;
  // Two consecutive controller-port addresses.
  localparam int unsigned PORT_COUNT = 2;

endpackage

// File: rtl/sbb_addr_decode.sv
module sbb_addr_decode
  import sbb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] VEC_ADDR  = 16'hFFFC,
  parameter logic [15:0] PORT_ADDR = 16'h4016
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              bus_read,
  output src_e              src,
  output logic              port_read
);

  // The stub starts right after the last port address.
  localparam int unsigned STUB_BASE = int'(PORT_ADDR) + PORT_COUNT;

  logic [VEC_LEN-1:0]    vec_hit;
  logic [PORT_COUNT-1:0] port_hit;
  logic [STUB_LEN-1:0]   stub_hit;

  for (genvar v = 0; v < VEC_LEN; v++) begin : g_vec
    localparam logic [ADDR_W-1:0] VA = ADDR_W'(int'(VEC_ADDR) + v);
    assign vec_hit[v] = (addr == VA);
  end

  for (genvar p = 0; p < PORT_COUNT; p++) begin : g_port
    localparam logic [ADDR_W-1:0] PA = ADDR_W'(int'(PORT_ADDR) + p);
    assign port_hit[p] = (addr == PA);
  end

  for (genvar s = 0; s < STUB_LEN; s++) begin : g_stub
    localparam logic [ADDR_W-1:0] SA = ADDR_W'(STUB_BASE + s);
    assign stub_hit[s] = (addr == SA);
  end

  always_comb begin
    src = SRC_NONE;
    if (bus_read) begin
      if (vec_hit[0])       src = SRC_VEC_LO;
      else if (vec_hit[1])  src = SRC_VEC_HI;
      else if (|port_hit)   src = SRC_PORT;
      else if (stub_hit[0]) src = SRC_JMP_OP;
      else if (stub_hit[1]) src = SRC_JMP_LO;
      else if (stub_hit[2]) src = SRC_JMP_HI;
    end
  end

  assign port_read = bus_read & (|port_hit);

endmodule

// File: rtl/sbb_serial_rx.sv
module sbb_serial_rx #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              irq_n,
  input  logic              d1_n,
  output logic [DATA_W-1:0] rx_byte,
  output logic [CNT_W-1:0]  rx_count,
  output logic              rx_done,
  output logic              fall_evt,
  output logic              shift_evt
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic irq_q;

  // Line bit is inverted relative to the data bus.
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] cur,
                                                 input logic line_n);
    return {cur[DATA_W-2:0], ~line_n};
  endfunction

  assign fall_evt  = irq_q & ~irq_n;
  assign rx_done   = (rx_count == FULL);
  assign shift_evt = enable & fall_evt & ~rx_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q    <= 1'b1;
      rx_count <= '0;
      rx_byte  <= '0;
    end else begin
      irq_q <= irq_n;
      if (!enable) begin
        rx_count <= '0;
        rx_byte  <= '0;
      end else if (shift_evt) begin
        rx_count <= rx_count + 1'b1;
        rx_byte  <= shift_in(rx_byte, d1_n);
      end
    end
  end

endmodule

// File: rtl/sbb_bus_drive.sv
module sbb_bus_drive
  import sbb_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter logic [7:0]  JMP_OPCODE = 8'h4C
) (
  input  src_e              src,
  input  logic [DATA_W-1:0] target_lo,
  input  logic [DATA_W-1:0] target_hi,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] drive_mask,
  output logic [DATA_W-1:0] data_out,
  output logic [DATA_W-1:0] data_oe
);

  logic [DATA_W-1:0] sel_byte;
  logic              drive;

  function automatic logic [DATA_W-1:0] pick(input src_e s,
                                             input logic [DATA_W-1:0] lo,
                                             input logic [DATA_W-1:0] hi,
                                             input logic [DATA_W-1:0] rx);
    case (s)
      SRC_VEC_LO, SRC_JMP_LO: return lo;
      SRC_VEC_HI, SRC_JMP_HI: return hi;
      SRC_JMP_OP:             return DATA_W'(JMP_OPCODE);
      SRC_PORT:               return rx;
      default:                return '0;
    endcase
  endfunction

  always_comb begin
    sel_byte = pick(src, target_lo, target_hi, rx_byte);
    case (src)
      SRC_NONE: drive = 1'b0;
      SRC_PORT: drive = rx_done;
      default:  drive = 1'b1;
    endcase
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign data_oe[b]  = drive & drive_mask[b];
    assign data_out[b] = drive & sel_byte[b];
  end

endmodule

// File: rtl/stream_boot_bridge.sv
module stream_boot_bridge
  import sbb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter logic [15:0] VEC_ADDR   = 16'hFFFC,
  parameter logic [15:0] PORT_ADDR  = 16'h4016,
  parameter logic [7:0]  JMP_OPCODE = 8'h4C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              m2,
  input  logic              irq_n,
  input  logic              port_d1_n,
  input  logic [DATA_W-1:0] drive_mask,
  output logic [DATA_W-1:0] data_out,
  output logic [DATA_W-1:0] data_oe
);

  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  // Both the vector and the stub point back at the first port address.
  localparam logic [2*DATA_W-1:0] TARGET = (2*DATA_W)'(PORT_ADDR);

  logic              bus_read;
  logic              port_read;
  src_e              src;
  logic [DATA_W-1:0] rx_byte;
  logic [CNT_W-1:0]  rx_count;
  logic              rx_done;
  logic              fall_evt;
  logic              shift_evt;

  assign bus_read = rst_n & m2 & cpu_rw;

  sbb_addr_decode #(
    .ADDR_W   (ADDR_W),
    .VEC_ADDR (VEC_ADDR),
    .PORT_ADDR(PORT_ADDR)
  ) u_decode (
    .addr     (cpu_addr),
    .bus_read (bus_read),
    .src      (src),
    .port_read(port_read)
  );

  sbb_serial_rx #(
    .DATA_W(DATA_W)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (port_read),
    .irq_n    (irq_n),
    .d1_n     (port_d1_n),
    .rx_byte  (rx_byte),
    .rx_count (rx_count),
    .rx_done  (rx_done),
    .fall_evt (fall_evt),
    .shift_evt(shift_evt)
  );

  sbb_bus_drive #(
    .DATA_W    (DATA_W),
    .JMP_OPCODE(JMP_OPCODE)
  ) u_drive (
    .src       (src),
    .target_lo (TARGET[DATA_W-1:0]),
    .target_hi (TARGET[2*DATA_W-1:DATA_W]),
    .rx_byte   (rx_byte),
    .rx_done   (rx_done),
    .drive_mask(drive_mask),
    .data_out  (data_out),
    .data_oe   (data_oe)
  );

endmodule

// File: rtl/stream_boot_bridge_chk.sv
module stream_boot_bridge_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter logic [15:0] VEC_ADDR  = 16'hFFFC,
  parameter logic [15:0] PORT_ADDR = 16'h4016,
  localparam int unsigned CNT_W    = $clog2(DATA_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rw,
  input logic              m2,
  input logic [DATA_W-1:0] drive_mask,
  input logic [DATA_W-1:0] data_out,
  input logic [DATA_W-1:0] data_oe,
  input logic              port_read,
  input logic              rx_done,
  input logic [CNT_W-1:0]  rx_count,
  input logic [DATA_W-1:0] rx_byte,
  input logic              shift_evt
);

  localparam logic [ADDR_W-1:0] VEC_LO_A = ADDR_W'(VEC_ADDR);
  localparam logic [ADDR_W-1:0] VEC_HI_A = ADDR_W'(int'(VEC_ADDR) + 1);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (data_oe == '0 && data_out == '0));

  assert_vector_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m2 && cpu_rw && cpu_addr == VEC_LO_A) |-> data_out == PORT_ADDR[DATA_W-1:0]);

  assert_vector_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m2 && cpu_rw && cpu_addr == VEC_HI_A) |-> data_out == PORT_ADDR[2*DATA_W-1:DATA_W]);

  assert_one_bit_per_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> rx_count == CNT_W'($past(rx_count) + 1'b1));

  assert_drive_after_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_read && data_oe != '0) |-> rx_done);

  assert_byte_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_read && rx_done && $past(port_read && rx_done)) |-> $stable(rx_byte));

  assert_clear_on_m2_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(m2) |=> rx_count == '0);

  assert_mask_bound_R8: assert property (@(posedge clk)
    (data_oe & ~drive_mask) == '0);

  assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!m2 || !cpu_rw) |-> data_oe == '0);

endmodule

bind stream_boot_bridge stream_boot_bridge_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .VEC_ADDR (VEC_ADDR),
  .PORT_ADDR(PORT_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_rw    (cpu_rw),
  .m2        (m2),
  .drive_mask(drive_mask),
  .data_out  (data_out),
  .data_oe   (data_oe),
  .port_read (port_read),
  .rx_done   (rx_done),
  .rx_count  (rx_count),
  .rx_byte   (rx_byte),
  .shift_evt (shift_evt)
);

// File: tb/stream_boot_bridge_bench.sv
module stream_boot_bridge_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'hFFFC;
  logic        cpu_rw = 1'b1;
  logic        m2 = 1'b1;
  logic        irq_n = 1'b1;
  logic        port_d1_n = 1'b1;
  logic [7:0]  drive_mask = 8'hFF;
  logic [7:0]  data_out;
  logic [7:0]  data_oe;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // Reference model state
  int   m_cnt = 0;
  bit   m_prev_irq = 1;
  logic m_bits[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_boot_bridge u_stream_boot_bridge (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .m2(m2),
    .irq_n(irq_n), .port_d1_n(port_d1_n), .drive_mask(drive_mask),
    .data_out(data_out), .data_oe(data_oe)
  );

  function automatic bit is_port(input logic [15:0] a);
    return a == 16'h4016 || a == 16'h4017;
  endfunction

  // Model update on each clock, using the inputs that were stable at the edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_prev_irq = 1; m_bits.delete();
    end else begin
      bit fell;
      fell = m_prev_irq && !irq_n;
      m_prev_irq = irq_n;
      if (!(m2 && cpu_rw && is_port(cpu_addr))) begin
        m_cnt = 0; m_bits.delete();
      end else if (fell && m_cnt < 8) begin
        m_bits.push_back(~port_d1_n);
        m_cnt++;
      end
    end
  end

  task automatic model_expect(output logic [7:0] eo, output logic [7:0] eoe);
    logic [7:0] v;
    bit drive;
    v = 8'h00; drive = 0;
    if (rst_n && m2 && cpu_rw) begin
      case (cpu_addr)
        16'hFFFC: begin v = 8'h16; drive = 1; end
        16'hFFFD: begin v = 8'h40; drive = 1; end
        16'h4018: begin v = 8'h4C; drive = 1; end
        16'h4019: begin v = 8'h16; drive = 1; end
        16'h401A: begin v = 8'h40; drive = 1; end
        16'h4016, 16'h4017: if (m_cnt == 8) begin
          foreach (m_bits[i]) v = {v[6:0], m_bits[i]};
          drive = 1;
        end
        default: ;
      endcase
    end
    eo  = drive ? v : 8'h00;
    eoe = drive ? drive_mask : 8'h00;
  endtask

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    logic [7:0] eo, eoe;
    if (!finished) begin
      model_expect(eo, eoe);
      checks++;
      if (data_out !== eo || data_oe !== eoe) begin
        errors++;
        $display("FAIL %s (model): data_out=%h data_oe=%h expected %h %h",
                 cur_req, data_out, data_oe, eo, eoe);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_bus(input string req, input logic [7:0] eo, input logic [7:0] eoe);
    checks++;
    if (data_out !== eo || data_oe !== eoe) begin
      errors++;
      $display("FAIL %s: data_out=%h data_oe=%h expected %h %h", req, data_out, data_oe, eo, eoe);
    end
  endtask

  task automatic bus_read(input logic [15:0] a, input logic [7:0] mask);
    cpu_addr = a; cpu_rw = 1'b1; drive_mask = mask; m2 = 1'b1; tick();
  endtask

  // One port read with a given number of irq falling edges, MSB first.
  task automatic port_read(input logic [15:0] a, input logic [7:0] b,
                           input int edges, input logic [7:0] mask);
    cpu_addr = a; cpu_rw = 1'b1; drive_mask = mask; m2 = 1'b0; irq_n = 1'b1; tick();
    m2 = 1'b1; tick();
    for (int i = 0; i < edges; i++) begin
      port_d1_n = ~b[7 - (i % 8)]; tick();
      irq_n = 1'b0; tick();
      irq_n = 1'b1;
    end
    tick(); tick();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset with an active vector read on the bus
    cur_req = "R1";
    repeat (3) tick();
    expect_bus("R1", 8'h00, 8'h00);
    rst_n = 1'b1; tick();

    cur_req = "R2";
    bus_read(16'hFFFC, 8'hFF); expect_bus("R2", 8'h16, 8'hFF);
    bus_read(16'hFFFD, 8'hFF); expect_bus("R2", 8'h40, 8'hFF);

    cur_req = "R3";
    bus_read(16'h4018, 8'hFF); expect_bus("R3", 8'h4C, 8'hFF);
    bus_read(16'h4019, 8'hFF); expect_bus("R3", 8'h16, 8'hFF);
    bus_read(16'h401A, 8'hFF); expect_bus("R3", 8'h40, 8'hFF);

    cur_req = "R9";
    bus_read(16'h401B, 8'hFF); expect_bus("R9", 8'h00, 8'h00);
    bus_read(16'h0000, 8'hFF); expect_bus("R9", 8'h00, 8'h00);
    cpu_rw = 1'b0; cpu_addr = 16'hFFFC; tick(); expect_bus("R9", 8'h00, 8'h00);
    cpu_rw = 1'b1; m2 = 1'b0; tick(); expect_bus("R9", 8'h00, 8'h00);

    cur_req = "R4";
    port_read(16'h4016, 8'hA5, 8, 8'hFF);
    expect_bus("R4", 8'hA5, 8'hFF);
    cur_req = "R5";
    m2 = 1'b0; tick();
    port_read(16'h4017, 8'h81, 8, 8'hFF);
    expect_bus("R5", 8'h81, 8'hFF);
    m2 = 1'b0; tick();
    port_read(16'h4016, 8'hFF, 7, 8'hFF);
    expect_bus("R5", 8'h00, 8'h00);
    m2 = 1'b0; tick();

    cur_req = "R8";
    port_read(16'h4017, 8'h3C, 8, 8'hE0);
    expect_bus("R8", 8'h3C, 8'hE0);
    m2 = 1'b0; tick();
    bus_read(16'h4018, 8'h1F); expect_bus("R8", 8'h4C, 8'h1F);

    cur_req = "R6";
    port_read(16'h4016, 8'hC6, 10, 8'hFF);
    expect_bus("R6", 8'hC6, 8'hFF);
    m2 = 1'b0; tick();

    cur_req = "R7";
    port_read(16'h4016, 8'hF0, 5, 8'hFF);
    m2 = 1'b0; tick();
    port_read(16'h4016, 8'h5A, 3, 8'hFF);
    expect_bus("R7", 8'h00, 8'h00);
    // edges outside a port read must not count
    cpu_addr = 16'h4018;
    for (int i = 0; i < 6; i++) begin irq_n = 1'b0; tick(); irq_n = 1'b1; tick(); end
    port_read(16'h4017, 8'h5A, 8, 8'hFF);
    expect_bus("R7", 8'h5A, 8'hFF);
    m2 = 1'b0; tick();
    tick();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule